// File: doc/BRIEF.md
# Dual-Event Timer Channel

This block is one channel of a timer unit. It watches a single input pin and drives a single output pin, measured against two free-running 24-bit time bases that arrive from outside as inputs. The channel holds two events. Each event has a match register, a capture register and a latch. Event 1 compares its match value with greater-or-equal (modulo 2^24), and event 2 compares with exact equality. An event fires on a match or on a selected transition of the conditioned input. When it fires, its latch sets and its capture register stores the time base chosen for it. A match can also drive the output pin to a programmed state.

The input passes through a two-flop synchronizer. It then passes through a digital filter that can be bypassed, and then an edge detector. The two latches are independent of each other, so event 2 may be latched before event 1. Each latch has its own clear strobe. A single-event mode leaves event 2 disarmed. A half-rate option runs all the channel logic on every second clock. A service request is raised while either latch is set.

Top module: `tmr_dual_chan`

## Requirements
- R1: In reset, pin_out, pin_lvl, both latches, both capture registers, both match registers and srq are all 0.
- R2: With the filter bypassed at full rate, a level applied to pin_in shows up on pin_lvl after the third rising clock edge. The edge at that same clock edge can set a latch.
- R3: With the filter enabled, a new level is accepted only on the flt_len-th consecutive tick on which the synchronized input differs from pin_lvl. A flt_len of 0 behaves like 1. A shorter disagreement leaves pin_lvl unchanged.
- R4: The per-event edge select works as follows: 00 = no transition, 01 = rising, 10 = falling, 11 = both. A selected transition on a tick sets that event's latch and loads its capture register with the chosen time base.
- R5: Event 1 matches when (time base - match1) mod 2^24 is below 2^23. Its match fires once the time base reaches or passes the value, including across wrap.
- R6: Event 2 matches only on a tick where the chosen time base equals match2 exactly.
- R7: While an event's latch is set, that event does not match, does not capture and does not act on the pin.
- R8: The two latches are independent, and event 2 may latch while event 1 stays clear. Writing clr[i] high clears latch i on the next edge. It takes priority over a set on the same tick.
- R9: A match drives pin_out by its action: 00 keep, 01 set, 10 clear, 11 toggle. If both events match on one tick, action 1 is applied first and action 2 is applied to its result.
- R10: With dual_mode low, event 2 never latches or acts, and event 1 works as usual.
- R11: With half_rate high, the filter, edge detector, matches, latches and pin actions advance only on every second clock. pin_out therefore never changes on two consecutive clocks.
- R12: srq is high exactly when at least one latch is set. pin_lvl is the filtered input level.
- R13: Bit i of mat_sel chooses the time base for event i's comparator, and bit i of cap_sel chooses it for event i's capture (0 = tb_a, 1 = tb_b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_rate | input | 1 | Run channel logic on every second clock |
| dual_mode | input | 1 | Arm event 2 as well as event 1 |
| flt_bypass | input | 1 | Skip the input filter |
| flt_len | input | FLT_W | Ticks a new level must persist |
| tb_a | input | W | Time base A |
| tb_b | input | W | Time base B |
| pin_in | input | 1 | Asynchronous input pin |
| edge1 | input | 2 | Transition select for event 1 |
| edge2 | input | 2 | Transition select for event 2 |
| act1 | input | 2 | Pin action on event 1 match |
| act2 | input | 2 | Pin action on event 2 match |
| mat_sel | input | 2 | Time base select per comparator |
| cap_sel | input | 2 | Time base select per capture |
| mat_wr | input | 2 | Write strobe per match register |
| mat_wdata | input | W | Match write data |
| clr | input | 2 | Clear strobe per latch |
| pin_out | output | 1 | Output pin |
| pin_lvl | output | 1 | Filtered input level |
| lat | output | 2 | Event latches |
| cap1 | output | W | Event 1 capture |
| cap2 | output | W | Event 2 capture |
| srq | output | 1 | Service request |

## Verification
Both comparators can fire on the same tick, and then the two pin actions combine in a fixed order. The bench loads the same value into both match registers, with both comparators on time base A, and tries set-then-clear and clear-then-toggle pairs. It judges the resulting pin state against the sequential rule. A second collision is a clear strobe landing on the same tick as a transition. The reference model, run every cycle, expects the clear to win, with the capture still taken.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int TBW = 24;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        EDG_NONE = 2'b00,
        EDG_RISE = 2'b01,
        EDG_FALL = 2'b10,
        EDG_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic apply_act(input logic cur, input pin_act_e a);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction

    function automatic logic edge_hit(input edge_sel_e s, input edge_ev_t e);
        return (s[0] & e.rise) | (s[1] & e.fall);
    endfunction

endpackage

// File: rtl/tdc_infilt.sv
module tdc_infilt
    import tdc_pkg::*;
#(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             bypass,
    input  logic [FLT_W-1:0] len,
    input  logic             pin_in,
    output logic             lvl,
    output edge_ev_t         ev
);
    logic             sync1, sync2;
    logic [FLT_W-1:0] run_q, run_d;
    logic             lvl_q, lvl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
        end
    end

    always_comb begin
        lvl_d = lvl_q;
        run_d = '0;
        if (bypass) begin
            lvl_d = sync2;
        end else if (sync2 != lvl_q) begin
            if (({1'b0, run_q} + 1'b1) >= {1'b0, len}) lvl_d = sync2;
            else                                       run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (ce) begin
            lvl_q <= lvl_d;
            run_q <= run_d;
        end
    end

    assign ev.rise = ce & lvl_d & ~lvl_q;
    assign ev.fall = ce & ~lvl_d & lvl_q;
    assign lvl     = lvl_q;

endmodule

// File: rtl/tdc_cmp.sv
module tdc_cmp #(
    parameter int W  = 24,
    parameter int GE = 1
) (
    input  logic [W-1:0] tb,
    input  logic [W-1:0] mval,
    output logic         hit
);
    generate
        if (GE != 0) begin : g_ge
            logic [W-1:0] diff;
            assign diff = tb - mval;
            assign hit  = ~diff[W-1];
        end else begin : g_eq
            assign hit = (tb == mval);
        end
    endgenerate
endmodule

// File: rtl/tdc_evt.sv
module tdc_evt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic         en,
    input  logic         t_hit,
    input  logic         m_hit,
    input  logic         clr,
    input  logic [W-1:0] cap_val,
    output logic         lat,
    output logic [W-1:0] cap,
    output logic         mfire
);
    logic armed, set_ev;

    assign armed  = ce & en & ~lat;
    assign mfire  = armed & m_hit;
    assign set_ev = armed & (m_hit | t_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= 1'b0;
            cap <= '0;
        end else begin
            if (clr)         lat <= 1'b0;
            else if (set_ev) lat <= 1'b1;
            if (set_ev)      cap <= cap_val;
        end
    end
endmodule

// File: rtl/tmr_dual_chan.sv
module tmr_dual_chan
    import tdc_pkg::*;
#(
    parameter int W     = TBW,
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_rate,
    input  logic             dual_mode,
    input  logic             flt_bypass,
    input  logic [FLT_W-1:0] flt_len,
    input  logic [W-1:0]     tb_a,
    input  logic [W-1:0]     tb_b,
    input  logic             pin_in,
    input  logic [1:0]       edge1,
    input  logic [1:0]       edge2,
    input  logic [1:0]       act1,
    input  logic [1:0]       act2,
    input  logic [1:0]       mat_sel,
    input  logic [1:0]       cap_sel,
    input  logic [1:0]       mat_wr,
    input  logic [W-1:0]     mat_wdata,
    input  logic [1:0]       clr,
    output logic             pin_out,
    output logic             pin_lvl,
    output logic [1:0]       lat,
    output logic [W-1:0]     cap1,
    output logic [W-1:0]     cap2,
    output logic             srq
);
    localparam int NEV = 2;

    logic                    tgl, ce;
    edge_ev_t                ev;
    logic [NEV-1:0]          mfire;
    logic [NEV-1:0][W-1:0]   cap_q;
    logic                    pin_q, pin_d;

    always_ff @(posedge clk) begin
        if (rst) tgl <= 1'b0;
        else     tgl <= ~tgl;
    end
    assign ce = ~half_rate | tgl;

    tdc_infilt #(.FLT_W(FLT_W)) u_flt (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .bypass (flt_bypass),
        .len    (flt_len),
        .pin_in (pin_in),
        .lvl    (pin_lvl),
        .ev     (ev)
    );

    generate
        for (genvar e = 0; e < NEV; e++) begin : g_ev
            logic [W-1:0] mreg;
            logic [W-1:0] tb_m;
            logic [W-1:0] tb_c;
            logic         m_hit, t_hit, en;

            always_ff @(posedge clk) begin
                if (rst)            mreg <= '0;
                else if (mat_wr[e]) mreg <= mat_wdata;
            end

            assign tb_m  = mat_sel[e] ? tb_b : tb_a;
            assign tb_c  = cap_sel[e] ? tb_b : tb_a;
            assign en    = (e == 0) ? 1'b1 : dual_mode;
            assign t_hit = edge_hit(edge_sel_e'((e == 0) ? edge1 : edge2), ev);

            tdc_cmp #(.W(W), .GE((e == 0) ? 1 : 0)) u_cmp (
                .tb   (tb_m),
                .mval (mreg),
                .hit  (m_hit)
            );

            tdc_evt #(.W(W)) u_evt (
                .clk     (clk),
                .rst     (rst),
                .ce      (ce),
                .en      (en),
                .t_hit   (t_hit),
                .m_hit   (m_hit),
                .clr     (clr[e]),
                .cap_val (tb_c),
                .lat     (lat[e]),
                .cap     (cap_q[e]),
                .mfire   (mfire[e])
            );
        end
    endgenerate

    always_comb begin
        pin_d = pin_q;
        if (mfire[0]) pin_d = apply_act(pin_d, pin_act_e'(act1));
        if (mfire[1]) pin_d = apply_act(pin_d, pin_act_e'(act2));
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_d;
    end

    assign pin_out = pin_q;
    assign cap1    = cap_q[0];
    assign cap2    = cap_q[1];
    assign srq     = |lat;

endmodule

// File: rtl/tdc_chk.sv
module tdc_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         half_rate,
    input logic         dual_mode,
    input logic [1:0]   clr,
    input logic [1:0]   lat,
    input logic         pin_out,
    input logic [W-1:0] cap1,
    input logic [W-1:0] cap2
);
    // R8: a clear strobe empties its latch on the next edge
    p_clear1_r8: assert property (@(posedge clk) disable iff (rst)
        clr[0] |=> !lat[0]);
    p_clear2_r8: assert property (@(posedge clk) disable iff (rst)
        clr[1] |=> !lat[1]);

    // R7: a held latch blocks further captures
    p_cap1_hold_r7: assert property (@(posedge clk) disable iff (rst)
        lat[0] |=> $stable(cap1));
    p_cap2_hold_r7: assert property (@(posedge clk) disable iff (rst)
        lat[1] |=> $stable(cap2));

    // R10: single-event mode never latches event 2
    p_single_r10: assert property (@(posedge clk) disable iff (rst)
        !dual_mode |=> !$rose(lat[1]));

    // R11: at half rate the pin cannot move on two clocks in a row
    p_half_rate_r11: assert property (@(posedge clk) disable iff (rst)
        (half_rate && $past(half_rate) && !$stable(pin_out)) |=> $stable(pin_out));
endmodule

bind tmr_dual_chan tdc_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .half_rate (half_rate),
    .dual_mode (dual_mode),
    .clr       (clr),
    .lat       (lat),
    .pin_out   (pin_out),
    .cap1      (cap1),
    .cap2      (cap2)
);

// File: tb/test_tmr_dual_chan.sv
module test_tmr_dual_chan;
    localparam int W = 24;
    localparam int FW = 4;
    localparam logic [W-1:0] MASK = {W{1'b1}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic half_rate = 1'b0, dual_mode = 1'b1, flt_bypass = 1'b1;
    logic [FW-1:0] flt_len = '0;
    logic [W-1:0] tb_a = 24'hFFFF00, tb_b = 24'h000100;
    logic pin_in = 1'b0;
    logic [1:0] edge1 = 2'b00, edge2 = 2'b00, act1 = 2'b00, act2 = 2'b00;
    logic [1:0] mat_sel = 2'b00, cap_sel = 2'b00, mat_wr = 2'b00, clr = 2'b11;
    logic [W-1:0] mat_wdata = '0;
    logic pin_out, pin_lvl, srq;
    logic [1:0] lat;
    logic [W-1:0] cap1, cap2;

    int vectors = 0;
    int errors = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #5 clk = ~clk;

    tmr_dual_chan #(.W(W), .FLT_W(FW)) i_tmr_dual_chan (
        .clk(clk), .rst(rst), .half_rate(half_rate), .dual_mode(dual_mode),
        .flt_bypass(flt_bypass), .flt_len(flt_len), .tb_a(tb_a), .tb_b(tb_b),
        .pin_in(pin_in), .edge1(edge1), .edge2(edge2), .act1(act1), .act2(act2),
        .mat_sel(mat_sel), .cap_sel(cap_sel), .mat_wr(mat_wr), .mat_wdata(mat_wdata),
        .clr(clr), .pin_out(pin_out), .pin_lvl(pin_lvl), .lat(lat),
        .cap1(cap1), .cap2(cap2), .srq(srq)
    );

    // free-running time bases, advanced away from the rising edge
    always @(negedge clk) begin
        tb_a <= tb_a + 24'd1;
        tb_b <= tb_b + 24'd3;
    end

    // ---------------- behavioural reference ----------------
    bit m_tgl, m_s1, m_s2, m_lvl, m_pin;
    int m_run;
    bit m_lat[2];
    logic [W-1:0] m_cap[2];
    logic [W-1:0] m_mat[2];

    always @(posedge clk) begin
        if (rst) begin
            m_tgl = 0; m_s1 = 0; m_s2 = 0; m_lvl = 0; m_pin = 0; m_run = 0;
            for (int i = 0; i < 2; i++) begin
                m_lat[i] = 0; m_cap[i] = '0; m_mat[i] = '0;
            end
        end else begin
            bit tick, old_s2, nl, rise, fall, mh, th, arm, pinv;
            bit mf[2];
            bit st[2];
            logic [W-1:0] tbm;
            logic [1:0] ec, ac;
            tick = !half_rate || m_tgl;
            m_tgl = !m_tgl;
            old_s2 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            rise = 0; fall = 0;
            if (tick) begin
                nl = m_lvl;
                if (flt_bypass) begin
                    nl = old_s2; m_run = 0;
                end else if (old_s2 != m_lvl) begin
                    if (m_run + 1 >= int'(flt_len)) begin nl = old_s2; m_run = 0; end
                    else m_run = m_run + 1;
                end else m_run = 0;
                rise = nl && !m_lvl;
                fall = !nl && m_lvl;
                m_lvl = nl;
            end
            for (int i = 0; i < 2; i++) begin
                tbm = mat_sel[i] ? tb_b : tb_a;
                if (i == 0) mh = ((tbm - m_mat[0]) & MASK) < 24'h800000;
                else        mh = (tbm == m_mat[1]);
                ec = (i == 0) ? edge1 : edge2;
                th = (ec[0] && rise) || (ec[1] && fall);
                arm = tick && (i == 0 || dual_mode) && !m_lat[i];
                mf[i] = arm && mh;
                st[i] = arm && (mh || th);
                if (st[i]) m_cap[i] = cap_sel[i] ? tb_b : tb_a;
                if (clr[i]) m_lat[i] = 0;
                else if (st[i]) m_lat[i] = 1;
                if (mat_wr[i]) m_mat[i] = mat_wdata;
            end
            pinv = m_pin;
            for (int i = 0; i < 2; i++) begin
                if (mf[i]) begin
                    ac = (i == 0) ? act1 : act2;
                    case (ac)
                        2'b01: pinv = 1;
                        2'b10: pinv = 0;
                        2'b11: pinv = !pinv;
                        default: ;
                    endcase
                end
            end
            m_pin = pinv;
        end
    end

    // compare every clock, away from the rising edge
    always @(negedge clk) begin
        if (!finished) begin
            bit bad;
            bad = 0;
            vectors++;
            if (pin_out !== m_pin) begin bad = 1;
                $display("FAIL %s pin_out act=%0b exp=%0b t=%0t", cur_req, pin_out, m_pin, $time); end
            if (pin_lvl !== m_lvl) begin bad = 1;
                $display("FAIL %s pin_lvl act=%0b exp=%0b t=%0t", cur_req, pin_lvl, m_lvl, $time); end
            if (lat !== {m_lat[1], m_lat[0]}) begin bad = 1;
                $display("FAIL %s lat act=%b exp=%b t=%0t", cur_req, lat, {m_lat[1], m_lat[0]}, $time); end
            if (cap1 !== m_cap[0]) begin bad = 1;
                $display("FAIL %s cap1 act=%h exp=%h t=%0t", cur_req, cap1, m_cap[0], $time); end
            if (cap2 !== m_cap[1]) begin bad = 1;
                $display("FAIL %s cap2 act=%h exp=%h t=%0t", cur_req, cap2, m_cap[1], $time); end
            if (srq !== (m_lat[0] || m_lat[1])) begin bad = 1;
                $display("FAIL R12 srq act=%0b exp=%0b t=%0t", srq, m_lat[0] || m_lat[1], $time); end
            if (bad) errors++;
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic write_match(input logic [1:0] which, input logic [W-1:0] v);
        mat_wdata = v; mat_wr = which;
        step(1);
        mat_wr = 2'b00;
    endtask

    task automatic clear_lat(input logic [1:0] which);
        clr = which;
        step(1);
        clr = 2'b00;
    endtask

    initial begin
        step(4);
        cur_req = "R1";
        chk(pin_out == 0 && pin_lvl == 0 && srq == 0, "R1", "outputs", {22'd0, pin_out, srq}, '0);
        chk(lat == 0 && cap1 == 0 && cap2 == 0, "R1", "latches", {22'd0, lat}, '0);
        rst = 0;
        // park both matches where they cannot fire
        write_match(2'b01, tb_a + 24'h400000);
        write_match(2'b10, tb_a - 24'd50);
        step(2);
        clr = 2'b00;
        step(2);
        clear_lat(2'b11);
        step(2);

        // R2 / R4: bypassed path, rising edge on event 1
        cur_req = "R2";
        edge1 = 2'b01;
        pin_in = 1;
        step(2);
        chk(lat[0] == 0, "R2", "lat0 before third edge", {23'd0, lat[0]}, '0);
        step(1);
        chk(lat[0] == 1 && pin_lvl == 1, "R2", "lat0/level on third edge", {22'd0, lat[0], pin_lvl}, 24'd3);
        cur_req = "R4";
        step(3);

        // R8: independent clear and unordered latching
        cur_req = "R8";
        clear_lat(2'b01);
        chk(lat[0] == 0, "R8", "lat0 cleared", {23'd0, lat[0]}, '0);
        edge2 = 2'b10;
        pin_in = 0;
        step(5);
        chk(lat == 2'b10, "R8", "event2 latched first", {22'd0, lat}, 24'd2);
        chk(srq == 1, "R12", "srq with latch2 only", {23'd0, srq}, 24'd1);
        clr = 2'b01;
        pin_in = 1;
        step(5);
        chk(lat[0] == 0, "R8", "clear beats set", {23'd0, lat[0]}, '0);
        clr = 2'b00;
        clear_lat(2'b11);
        step(2);

        // R3: filter rejects a short glitch, accepts a long level
        cur_req = "R3";
        flt_bypass = 0; flt_len = 4'd4; edge1 = 2'b11; edge2 = 2'b00;
        step(3);
        pin_in = 0;
        step(2);
        pin_in = 1;
        step(8);
        chk(pin_lvl == 1 && lat[0] == 0, "R3", "glitch rejected", {22'd0, pin_lvl, lat[0]}, 24'd2);
        pin_in = 0;
        step(5);
        chk(pin_lvl == 1, "R3", "level held before count", {23'd0, pin_lvl}, 24'd1);
        step(1);
        chk(pin_lvl == 0 && lat[0] == 1, "R3", "level accepted", {22'd0, pin_lvl, lat[0]}, 24'd1);
        flt_len = 4'd0;
        pin_in = 1;
        step(6);
        edge1 = 2'b00;
        clear_lat(2'b11);
        step(2);

        // R5: greater-or-equal match across wrap, then a value already passed
        cur_req = "R5";
        act1 = 2'b01;
        write_match(2'b01, tb_a + 24'h000120);
        clear_lat(2'b01);
        step(280);
        chk(pin_out == 0, "R5", "no early match", {23'd0, pin_out}, '0);
        step(20);
        chk(pin_out == 1 && lat[0] == 1, "R5", "match after wrap", {22'd0, pin_out, lat[0]}, 24'd3);
        act1 = 2'b10;
        write_match(2'b01, tb_a - 24'd100);
        clear_lat(2'b01);
        step(2);
        chk(pin_out == 0, "R5", "passed value fires", {23'd0, pin_out}, '0);

        // R6: equality only
        cur_req = "R6";
        act2 = 2'b11;
        write_match(2'b10, tb_a - 24'd3);
        clear_lat(2'b10);
        step(10);
        chk(lat[1] == 0, "R6", "passed value ignored", {23'd0, lat[1]}, '0);
        write_match(2'b10, tb_a + 24'd20);
        step(25);
        chk(lat[1] == 1 && pin_out == 1, "R6", "exact equality", {22'd0, lat[1], pin_out}, 24'd3);

        // R7: latched event blocks a second match
        cur_req = "R7";
        write_match(2'b10, tb_a + 24'd10);
        step(15);
        chk(pin_out == 1, "R7", "blocked toggle", {23'd0, pin_out}, 24'd1);

        // R9: simultaneous matches combine in order
        cur_req = "R9";
        act1 = 2'b01; act2 = 2'b10;
        write_match(2'b11, tb_a + 24'd20);
        clear_lat(2'b11);
        step(25);
        chk(pin_out == 0 && lat == 2'b11, "R9", "set then clear", {22'd0, pin_out, lat[0]}, 24'd1);
        act1 = 2'b10; act2 = 2'b11;
        write_match(2'b11, tb_a + 24'd20);
        clear_lat(2'b11);
        step(25);
        chk(pin_out == 1, "R9", "clear then toggle", {23'd0, pin_out}, 24'd1);

        // R13: time base B for comparator and capture
        cur_req = "R13";
        act1 = 2'b10; mat_sel = 2'b01; cap_sel = 2'b01;
        write_match(2'b01, tb_b + 24'd60);
        clear_lat(2'b11);
        step(15);
        chk(pin_out == 1, "R13", "B match not yet", {23'd0, pin_out}, 24'd1);
        step(15);
        chk(pin_out == 0 && lat[0] == 1, "R13", "B match fired", {22'd0, pin_out, lat[0]}, 24'd1);
        mat_sel = 2'b00; cap_sel = 2'b10;
        write_match(2'b11, tb_a + 24'h400000);

        // R10: single-event mode
        cur_req = "R10";
        dual_mode = 0; edge2 = 2'b11; flt_bypass = 1;
        clear_lat(2'b11);
        pin_in = 0;
        step(6);
        pin_in = 1;
        step(6);
        chk(lat[1] == 0, "R10", "event2 disarmed", {23'd0, lat[1]}, '0);
        dual_mode = 1;
        edge2 = 2'b00;
        step(2);

        // R11: half rate
        cur_req = "R11";
        half_rate = 1; edge1 = 2'b10; act1 = 2'b11; act2 = 2'b11;
        clear_lat(2'b11);
        pin_in = 0;
        step(10);
        chk(lat[0] == 1, "R11", "edge at half rate", {23'd0, lat[0]}, 24'd1);
        write_match(2'b01, tb_a + 24'd9);
        write_match(2'b10, tb_a + 24'd12);
        clear_lat(2'b11);
        step(40);
        flt_bypass = 0; flt_len = 4'd3; edge1 = 2'b11;
        clear_lat(2'b11);
        pin_in = 1;
        step(20);
        chk(lat[0] == 1 && pin_lvl == 1, "R11", "filtered edge at half rate", {22'd0, lat[0], pin_lvl}, 24'd3);
        half_rate = 0;
        step(10);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog %s act=running exp=done", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule